// File: doc/BRIEF.md
# Periodic Endpoint Bus-Time Calculator

This unit turns the parameters of one periodic endpoint into the bus time that one service of that endpoint takes, counted in byte-times. An admission-control path uses that number to decide whether the endpoint fits in a frame or microframe. The caller presents the bus speed class, the transfer kind, the maximum packet size, the split phase, the data direction and the number of transactions per microframe, and pulses `start`. One clock later the unit reports either a byte cost with `valid`, or a rejection with `err`.

The cost is built from four parts. The payload is charged at its worst-case bit-stuffed size. A fixed protocol overhead depends on speed and kind. A host-delay constant is always added. Split overhead applies on the high-speed side of a transaction translator. Low-speed payload is scaled by the ratio between the low-speed and full-speed clocks. For a split transaction, the payload is charged to whichever phase actually carries the data on the high-speed bus.

Top module: `bustime_calc`

## Requirements
- R1: The charged payload is floor(mps × 7 / 6) for every mps from 0 to 2047.
- R2: At full speed (speed=1, split=0, xn=1), cost = overhead + stuffed payload + 18. The overhead is 14 for kind=0 (non-isochronous), 10 for kind=1 (isochronous, host-to-device) and 11 for kind=2 (isochronous, device-to-host).
- R3: At low speed (speed=2, kind=0, split=0, xn=1), cost = 97 + 1 + 8 × stuffed payload + 18. Low speed with any isochronous kind is illegal.
- R4: At high speed without split (speed=0, split=0), cost = (overhead + stuffed payload + 18) × xn, with xn in 1..3. The overhead is 55 for kind=0 and 38 for either isochronous kind.
- R5: A high-speed split phase (split=1 start, split=2 complete) requires xn=1 and costs overhead + 18 + 4. The stuffed payload is added to the start phase when dir_in=0 (host-to-device) and to the complete phase when dir_in=1 (device-to-host).
- R6: `valid` or `err` is high for exactly the one cycle after the clock edge that samples `start`=1. Both are low otherwise. `cost` changes only on a cycle that raises `valid`.
- R7: An illegal request raises `err` instead of `valid` and leaves `cost` unchanged. Illegal requests are:
  - speed=3, kind=3 or split=3;
  - xn=0;
  - split≠0 at full or low speed;
  - xn≠1 unless the speed is high and split=0;
  - kind=1 with dir_in=1, or kind=2 with dir_in=0.
- R8: After reset, `valid`=0, `err`=0 and `cost`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, one cycle |
| speed | input | 2 | 0 high, 1 full, 2 low, 3 reserved |
| kind | input | 2 | 0 non-isochronous, 1 iso host-to-device, 2 iso device-to-host, 3 reserved |
| mps | input | 11 | Maximum packet size in bytes |
| split | input | 2 | 0 none, 1 start split, 2 complete split, 3 reserved |
| dir_in | input | 1 | 1 = device-to-host |
| xn | input | 2 | Transactions per microframe |
| cost | output | 16 | Bus time in byte-times |
| valid | output | 1 | Cost result strobe |
| err | output | 1 | Illegal-request strobe |

## Verification
The hardest cases to reach are the illegal combinations that are almost legal. Examples are an isochronous kind whose direction disagrees with `dir_in`, a split phase that asks for more than one transaction, or low speed paired with an isochronous kind. After any of these, the held cost must survive untouched.

Random stimulus therefore starts from a consistent request and then corrupts exactly one field in about a fifth of the vectors. This places rejections directly after accepted results with known costs. Directed vectors cover the packet-size extremes, the largest high-speed triple-transaction cost, and both payload placements for each split phase.

// File: rtl/bt_pkg.sv
package bt_pkg;
  typedef enum logic [1:0] {SPD_HIGH = 2'd0, SPD_FULL = 2'd1, SPD_LOW = 2'd2, SPD_RSVD = 2'd3} speed_e;
  typedef enum logic [1:0] {KND_NONISO = 2'd0, KND_ISO_OUT = 2'd1, KND_ISO_IN = 2'd2, KND_RSVD = 2'd3} kind_e;
  typedef enum logic [1:0] {PH_NONE = 2'd0, PH_START = 2'd1, PH_COMPLETE = 2'd2, PH_RSVD = 2'd3} phase_e;

  localparam int unsigned HOST_DELAY_B = 18;
  localparam int unsigned SPLIT_OH_B   = 4;
  localparam int unsigned HUB_LS_B     = 1;
  localparam int unsigned LS_OH_B      = 97;
  localparam int unsigned LS_CLK_MULT  = 8;
  localparam int unsigned FS_NONISO_B  = 14;
  localparam int unsigned FS_ISO_OUT_B = 10;
  localparam int unsigned FS_ISO_IN_B  = 11;
  localparam int unsigned HS_NONISO_B  = 55;
  localparam int unsigned HS_ISO_B     = 38;
endpackage

// File: rtl/bt_payload.sv
module bt_payload #(
  parameter int unsigned MPS_W  = 11,
  parameter int unsigned MULT   = 8,
  localparam int unsigned STF_W = MPS_W + 1,
  localparam int unsigned OUT_W = STF_W + $clog2(MULT)
) (
  input  logic [MPS_W-1:0] mps,
  input  logic             slow,
  output logic [STF_W-1:0] stuffed,
  output logic [OUT_W-1:0] charged
);
  logic [MPS_W+2:0] times7;

  always_comb begin
    times7  = ({3'b000, mps} << 3) - {3'b000, mps};
    stuffed = STF_W'(times7 / (MPS_W+3)'(6));
    charged = slow ? OUT_W'(stuffed) * OUT_W'(MULT) : OUT_W'(stuffed);
  end

  // R1: stuffing only grows the payload, by at most one sixth
  always_comb begin
    if (!$isunknown(mps)) begin
      p_stuff_bound_r1: assert ((STF_W+3)'(stuffed) * 6 <= (STF_W+3)'(mps) * 7 &&
                                (STF_W+3)'(stuffed) >= (STF_W+3)'(mps));
    end
  end
endmodule

// File: rtl/bt_overhead.sv
module bt_overhead
  import bt_pkg::*;
#(
  parameter int unsigned XN_W = 2
) (
  input  speed_e          spd,
  input  kind_e           knd,
  input  phase_e          ph,
  input  logic            dev_to_host,
  input  logic [XN_W-1:0] xn,
  output logic [7:0]      fixed_b,
  output logic            use_pay,
  output logic            slow,
  output logic            bad
);
  logic one_xn;

  always_comb begin
    one_xn  = (xn == XN_W'(1));
    fixed_b = 8'd0;
    use_pay = 1'b1;
    slow    = 1'b0;
    bad     = (xn == '0) || (knd == KND_RSVD) || (ph == PH_RSVD) ||
              (knd == KND_ISO_OUT && dev_to_host) || (knd == KND_ISO_IN && !dev_to_host);
    unique case (spd)
      SPD_HIGH: begin
        fixed_b = 8'((knd == KND_NONISO ? HS_NONISO_B : HS_ISO_B) + HOST_DELAY_B);
        if (ph != PH_NONE) begin
          fixed_b = fixed_b + 8'(SPLIT_OH_B);
          use_pay = (ph == PH_START) ? !dev_to_host : dev_to_host;
          if (!one_xn) bad = 1'b1;
        end
      end
      SPD_FULL: begin
        unique case (knd)
          KND_ISO_OUT: fixed_b = 8'(FS_ISO_OUT_B + HOST_DELAY_B);
          KND_ISO_IN:  fixed_b = 8'(FS_ISO_IN_B + HOST_DELAY_B);
          default:     fixed_b = 8'(FS_NONISO_B + HOST_DELAY_B);
        endcase
        if (ph != PH_NONE || !one_xn) bad = 1'b1;
      end
      SPD_LOW: begin
        fixed_b = 8'(LS_OH_B + HUB_LS_B + HOST_DELAY_B);
        slow    = 1'b1;
        if (knd != KND_NONISO || ph != PH_NONE || !one_xn) bad = 1'b1;
      end
      default: bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/bustime_calc.sv
module bustime_calc
  import bt_pkg::*;
#(
  parameter int unsigned MPS_W  = 11,
  parameter int unsigned COST_W = 16,
  parameter int unsigned XN_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        speed,
  input  logic [1:0]        kind,
  input  logic [MPS_W-1:0]  mps,
  input  logic [1:0]        split,
  input  logic              dir_in,
  input  logic [XN_W-1:0]   xn,
  output logic [COST_W-1:0] cost,
  output logic              valid,
  output logic              err
);
  localparam int unsigned STF_W = MPS_W + 1;
  localparam int unsigned PAY_W = STF_W + $clog2(LS_CLK_MULT);
  localparam int unsigned SUM_W = COST_W;
  localparam int unsigned PRD_W = SUM_W + XN_W;

  logic [STF_W-1:0]  stuffed;
  logic [PAY_W-1:0]  charged;
  logic [7:0]        fixed_b;
  logic              use_pay, slow, bad;
  logic [SUM_W-1:0]  per_xact;
  logic [PRD_W-1:0]  total;
  logic [COST_W-1:0] cost_q, cost_d;
  logic              valid_q, valid_d, err_q, err_d;

  bt_overhead #(.XN_W(XN_W)) u_oh (
    .spd(speed_e'(speed)), .knd(kind_e'(kind)), .ph(phase_e'(split)),
    .dev_to_host(dir_in), .xn(xn),
    .fixed_b(fixed_b), .use_pay(use_pay), .slow(slow), .bad(bad)
  );

  bt_payload #(.MPS_W(MPS_W), .MULT(LS_CLK_MULT)) u_pay (
    .mps(mps), .slow(slow), .stuffed(stuffed), .charged(charged)
  );

  always_comb begin
    per_xact = SUM_W'(fixed_b) + (use_pay ? SUM_W'(charged) : '0);
    total    = PRD_W'(per_xact) * PRD_W'(xn);
  end

  always_comb begin
    cost_d  = cost_q;
    valid_d = 1'b0;
    err_d   = 1'b0;
    if (start) begin
      if (bad) begin
        err_d = 1'b1;
      end else begin
        valid_d = 1'b1;
        cost_d  = COST_W'(total);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cost_q  <= '0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      err_q   <= err_d;
      if (valid_d) cost_q <= cost_d;
    end
  end

  assign cost  = cost_q;
  assign valid = valid_q;
  assign err   = err_q;

  p_strobe_needs_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q || err_q) |-> $past(start));
  p_one_outcome_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid_q && err_q));
  p_err_keeps_cost_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> $stable(cost_q));
  p_cost_only_on_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_q |-> $stable(cost_q));
  p_ls_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && $past(speed) == 2'd2) |-> cost_q >= COST_W'(116));
  p_min_cost_r2: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> cost_q >= COST_W'(28));
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    valid_d |-> total[PRD_W-1:COST_W] == '0);
endmodule

// File: tb/bustime_calc_tb.sv
module bustime_calc_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [1:0]  speed, kind, split, xn;
  logic [10:0] mps;
  logic        dir_in;
  logic [15:0] cost;
  logic        valid, err;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [15:0] last_cost;

  always #2.5 clk = ~clk;

  bustime_calc u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .speed(speed), .kind(kind),
    .mps(mps), .split(split), .dir_in(dir_in), .xn(xn),
    .cost(cost), .valid(valid), .err(err)
  );

  function automatic int stf(input int m);
    return (m * 7) / 6;
  endfunction

  function automatic bit illegal(input int s, k, p, d, n);
    if (s == 3 || k == 3 || p == 3 || n == 0) return 1;
    if (k == 1 && d == 1) return 1;
    if (k == 2 && d == 0) return 1;
    if (s != 0 && p != 0) return 1;
    if (!(s == 0 && p == 0) && n != 1) return 1;
    if (s == 2 && k != 0) return 1;
    return 0;
  endfunction

  function automatic int expect_cost(input int s, k, p, d, n, m);
    int oh;
    if (s == 1) begin
      oh = (k == 0) ? 14 : (k == 1) ? 10 : 11;
      return oh + stf(m) + 18;
    end
    if (s == 2) return 97 + 1 + 8 * stf(m) + 18;
    oh = (k == 0) ? 55 : 38;
    if (p == 0) return (oh + stf(m) + 18) * n;
    if ((p == 1 && d == 0) || (p == 2 && d == 1)) return oh + 22 + stf(m);
    return oh + 22;
  endfunction

  function automatic string tag(input int s, p, bit bad);
    if (bad) return "R7";
    if (s == 1) return "R2";
    if (s == 2) return "R3";
    if (p != 0) return "R5";
    return "R4";
  endfunction

  task automatic chk(input string r, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic apply(input int s, k, p, d, n, m);
    bit b;
    int e;
    b = illegal(s, k, p, d, n);
    @(negedge clk);
    speed = 2'(s); kind = 2'(k); split = 2'(p); dir_in = 1'(d); xn = 2'(n); mps = 11'(m);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk({tag(s, p, b), " valid"}, int'(valid), b ? 0 : 1);
    chk({tag(s, p, b), " err"}, int'(err), b ? 1 : 0);
    e = b ? int'(last_cost) : expect_cost(s, k, p, d, n, m);
    chk({tag(s, p, b), " cost"}, int'(cost), e);
    last_cost = 16'(e);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; speed = '0; kind = '0; split = '0;
    dir_in = 1'b0; xn = 2'd1; mps = '0; last_cost = '0;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk("R8 valid", int'(valid), 0);
    chk("R8 err", int'(err), 0);
    chk("R8 cost", int'(cost), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // directed corners
    apply(1, 0, 0, 0, 1, 0);      // R2 empty packet: 32
    apply(1, 0, 0, 0, 1, 5);      // R1 floor: 5*7/6 = 5
    apply(1, 2, 0, 1, 1, 6);      // R1 exact sixth: 7
    apply(2, 0, 0, 1, 1, 8);      // R3 116 + 72
    apply(2, 1, 0, 0, 1, 8);      // R3 LS iso illegal, R7
    apply(0, 0, 0, 1, 3, 2047);   // R4 largest: 7383
    apply(0, 1, 1, 0, 1, 188);    // R5 start split out with payload
    apply(0, 1, 2, 0, 1, 188);    // R5 complete split out, no payload
    apply(0, 2, 2, 1, 1, 1023);   // R5 complete split in with payload
    apply(0, 2, 1, 1, 1, 1023);   // R5 start split in, no payload
    apply(0, 0, 1, 0, 2, 64);     // R7 split with xn=2
    apply(0, 0, 0, 0, 0, 64);     // R7 xn=0
    apply(1, 1, 0, 1, 1, 64);     // R7 iso out marked device-to-host
    // R6 idle cycle: no strobe, cost held
    @(negedge clk);
    chk("R6 idle valid", int'(valid), 0);
    chk("R6 idle err", int'(err), 0);
    chk("R6 idle cost", int'(cost), int'(last_cost));
    for (int i = 0; i < 400; i++) begin
      int s, k, p, d, n, m, f;
      s = $urandom % 3;
      k = (s == 2) ? 0 : $urandom % 3;
      d = (k == 2) ? 1 : (k == 1) ? 0 : $urandom % 2;
      p = (s == 0) ? $urandom % 3 : 0;
      n = (s == 0 && p == 0) ? 1 + $urandom % 3 : 1;
      m = ($urandom % 4 == 0) ? (($urandom % 2) ? 2047 : 0) : $urandom % 2048;
      if ($urandom % 5 == 0) begin
        f = $urandom % 5;
        case (f)
          0: s = $urandom % 4;
          1: k = $urandom % 4;
          2: p = $urandom % 4;
          3: d = 1 - d;
          default: n = $urandom % 4;
        endcase
      end
      apply(s, k, p, d, n, m);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R6 watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule